// File: doc/BRIEF.md
# Load Data-Source Gating Predictor

This block sits beside the load pipeline of an out-of-order core. Normally a load probes the store queue and the level-one data cache in the same cycle, although only one of them ends up supplying the data. The predictor learns, per load address, which of the two structures a load tends to be served by. While the core runs a loop out of its loop buffer, it turns off the probe that is expected to be useless.

At issue, the load PC indexes a small table of saturating counters, and the block returns two registered probe enables. At resolution, the pipeline reports which structure actually held the data and which probes had been enabled for that load. The counter for that PC moves one step toward the structure that supplied the data. If the structure that supplied the data had been switched off, the block raises a replay request and says which probes the replay must use. Store-queue gating and cache gating each have their own configuration input, so either can be used alone or both together.

Top module: `ld_gate_pred`

## Requirements
- R1: After a synchronous reset, the outputs read as follows: both enables 1, `ld_valid` 0, `replay_req` 0, `replay_sq_en` 0. Every counter holds 1, which predicts the cache.
- R2: When `loop_mode` is 0, a load issued in that cycle receives `sq_en`=1 and `dc_en`=1, whatever the prediction.
- R3: In loop mode with `cfg_sq_gate`=1, a load whose counter is below 2 receives `sq_en`=0 and `dc_en`=1.
- R4: In loop mode with `cfg_dc_gate`=1, a load whose counter is 2 or more receives `dc_en`=0 and `sq_en`=1.
- R5: A structure whose gating configuration input is 0 is always enabled. The other structure can still be gated on its own.
- R6: `sq_en` and `dc_en` are never both 0.
- R7: Each resolution updates the counter selected by PC bits [7:2]. It adds 1 when `res_from_sq`=1 and subtracts 1 when it is 0. The counter saturates at 3 and at 0. PCs that share bits [7:2] share a counter.
- R8: A resolution with `res_from_sq`=1 and `res_sq_probed`=0 gives `replay_req`=1 and `replay_sq_en`=1 in the next cycle. The replay uses both structures.
- R9: A resolution with `res_from_sq`=0 and `res_dc_probed`=0 gives `replay_req`=1 and `replay_sq_en`=0 in the next cycle. The replay uses the cache only.
- R10: A resolution in which the supplying structure had been probed, or a cycle with no resolution, gives `replay_req`=0 in the next cycle.
- R11: Outputs are registered. An issue in one cycle produces `ld_valid`=1 and its enables in the next cycle. A cycle with no issue produces `ld_valid`=0 with both enables 1. When an issue and a resolution hit the same counter in the same cycle, the issue sees the counter value from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loop_mode | input | 1 | Core is executing from the loop buffer; gating allowed |
| cfg_sq_gate | input | 1 | Permit switching off the store-queue probe |
| cfg_dc_gate | input | 1 | Permit switching off the data-cache probe |
| iss_valid | input | 1 | A load issues this cycle |
| iss_pc | input | PC_W | PC of the issuing load |
| res_valid | input | 1 | A load resolves this cycle |
| res_pc | input | PC_W | PC of the resolving load |
| res_from_sq | input | 1 | 1: data came from the store queue, 0: from the cache |
| res_sq_probed | input | 1 | The resolving load had its store-queue probe enabled |
| res_dc_probed | input | 1 | The resolving load had its cache probe enabled |
| ld_valid | output | 1 | Enables below belong to a load issued in the previous cycle |
| sq_en | output | 1 | Store-queue probe enable |
| dc_en | output | 1 | Data-cache probe enable |
| replay_req | output | 1 | The load resolved in the previous cycle must be replayed |
| replay_sq_en | output | 1 | The replay must also probe the store queue (cache always probed) |

## Verification
The assertions check, on every cycle, the properties that depend only on the ports. Both probes are never off together. Outside loop mode, and for a structure whose gating is off, the probe stays on. A replay follows exactly those resolutions where the supplying structure was off, and its kind matches. A cycle with no issue leaves the enables high. The counter history cannot be seen from the ports, so only the bench's scenarios can show training, saturation at both ends, aliasing of PCs that share index bits, and the read-before-update order when an issue and a resolution touch one entry. The bench covers these by driving the cycle-accurate reference model through directed and random traffic.

// File: rtl/ld_gate_pkg.sv
package ld_gate_pkg;
  // data source reported at resolution
  typedef enum logic {
    SRC_DC = 1'b0,
    SRC_SQ = 1'b1
  } ld_src_e;

  typedef struct packed {
    logic sq_en;
    logic dc_en;
  } probe_t;

  localparam probe_t PROBE_BOTH = '{sq_en: 1'b1, dc_en: 1'b1};
endpackage

// File: rtl/ld_gate_table.sv
module ld_gate_table #(
  parameter int IDX_W = 6,
  parameter int CTR_W = 2,
  parameter int INIT  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CTR_W-1:0] rd_ctr,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_to_sq
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CMAX  = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] CMIN  = '0;
  localparam logic [CTR_W-1:0] CINIT = CTR_W'(INIT);

  logic [CTR_W-1:0] mem [DEPTH];
  logic [CTR_W-1:0] upd_cur;
  logic [CTR_W-1:0] upd_nxt;

  assign upd_cur = mem[upd_idx];
  assign rd_ctr  = mem[rd_idx];

  always_comb begin
    upd_nxt = upd_cur;
    if (upd_to_sq) begin
      if (upd_cur != CMAX) upd_nxt = upd_cur + 1'b1;
    end else begin
      if (upd_cur != CMIN) upd_nxt = upd_cur - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CINIT;
    end else if (upd_en) begin
      mem[upd_idx] <= upd_nxt;
    end
  end
endmodule

// File: rtl/ld_gate_decide.sv
module ld_gate_decide
  import ld_gate_pkg::*;
#(
  parameter int CTR_W = 2
) (
  input  logic [CTR_W-1:0] ctr,
  input  logic             loop_mode,
  input  logic             cfg_sq_gate,
  input  logic             cfg_dc_gate,
  output probe_t           probe,
  input  logic             res_valid,
  input  ld_src_e          res_src,
  input  logic             res_sq_probed,
  input  logic             res_dc_probed,
  output logic             need_replay,
  output logic             replay_with_sq
);
  localparam logic [CTR_W-1:0] CMID = CTR_W'(1 << (CTR_W - 1));

  logic pred_sq;
  logic sq_missed;
  logic dc_missed;

  assign pred_sq = (ctr >= CMID);

  always_comb begin
    probe = PROBE_BOTH;
    if (loop_mode) begin
      if (cfg_sq_gate && !pred_sq) probe.sq_en = 1'b0;
      if (cfg_dc_gate &&  pred_sq) probe.dc_en = 1'b0;
    end
  end

  assign sq_missed      = (res_src == SRC_SQ) && !res_sq_probed;
  assign dc_missed      = (res_src == SRC_DC) && !res_dc_probed;
  assign need_replay    = res_valid && (sq_missed || dc_missed);
  assign replay_with_sq = res_valid && sq_missed;
endmodule

// File: rtl/ld_gate_pred.sv
module ld_gate_pred
  import ld_gate_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2,
  parameter int IDX_W  = 6,
  parameter int CTR_W  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            loop_mode,
  input  logic            cfg_sq_gate,
  input  logic            cfg_dc_gate,
  input  logic            iss_valid,
  input  logic [PC_W-1:0] iss_pc,
  input  logic            res_valid,
  input  logic [PC_W-1:0] res_pc,
  input  logic            res_from_sq,
  input  logic            res_sq_probed,
  input  logic            res_dc_probed,
  output logic            ld_valid,
  output logic            sq_en,
  output logic            dc_en,
  output logic            replay_req,
  output logic            replay_sq_en
);
  localparam int CTR_INIT = 1;

  logic [IDX_W-1:0] iss_idx;
  logic [IDX_W-1:0] res_idx;
  logic [CTR_W-1:0] iss_ctr;
  probe_t           probe;
  logic             need_replay;
  logic             replay_with_sq;
  ld_src_e          res_src;

  assign iss_idx = iss_pc[PC_LSB +: IDX_W];
  assign res_idx = res_pc[PC_LSB +: IDX_W];
  assign res_src = res_from_sq ? SRC_SQ : SRC_DC;

  ld_gate_table #(
    .IDX_W(IDX_W),
    .CTR_W(CTR_W),
    .INIT (CTR_INIT)
  ) u_table (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (iss_idx),
    .rd_ctr   (iss_ctr),
    .upd_en   (res_valid),
    .upd_idx  (res_idx),
    .upd_to_sq(res_from_sq)
  );

  ld_gate_decide #(
    .CTR_W(CTR_W)
  ) u_decide (
    .ctr           (iss_ctr),
    .loop_mode     (loop_mode),
    .cfg_sq_gate   (cfg_sq_gate),
    .cfg_dc_gate   (cfg_dc_gate),
    .probe         (probe),
    .res_valid     (res_valid),
    .res_src       (res_src),
    .res_sq_probed (res_sq_probed),
    .res_dc_probed (res_dc_probed),
    .need_replay   (need_replay),
    .replay_with_sq(replay_with_sq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_valid     <= 1'b0;
      sq_en        <= 1'b1;
      dc_en        <= 1'b1;
      replay_req   <= 1'b0;
      replay_sq_en <= 1'b0;
    end else begin
      ld_valid     <= iss_valid;
      sq_en        <= iss_valid ? probe.sq_en : 1'b1;
      dc_en        <= iss_valid ? probe.dc_en : 1'b1;
      replay_req   <= need_replay;
      replay_sq_en <= replay_with_sq;
    end
  end
endmodule

// File: rtl/ld_gate_chk.sv
module ld_gate_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            loop_mode,
  input logic            cfg_sq_gate,
  input logic            cfg_dc_gate,
  input logic            iss_valid,
  input logic [PC_W-1:0] iss_pc,
  input logic            res_valid,
  input logic [PC_W-1:0] res_pc,
  input logic            res_from_sq,
  input logic            res_sq_probed,
  input logic            res_dc_probed,
  input logic            ld_valid,
  input logic            sq_en,
  input logic            dc_en,
  input logic            replay_req,
  input logic            replay_sq_en
);
  // R6
  never_both_off_chk: assert property (@(posedge clk) disable iff (rst)
    (sq_en || dc_en));

  // R2
  no_gate_outside_loop_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !loop_mode) |=> (ld_valid && sq_en && dc_en));

  // R5
  sq_cfg_off_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !cfg_sq_gate) |=> sq_en);

  // R5
  dc_cfg_off_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !cfg_dc_gate) |=> dc_en);

  // R8
  sq_miss_replay_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_from_sq && !res_sq_probed) |=> (replay_req && replay_sq_en));

  // R9
  dc_miss_replay_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_from_sq && !res_dc_probed) |=> (replay_req && !replay_sq_en));

  // R10
  no_spurious_replay_chk: assert property (@(posedge clk) disable iff (rst)
    (!res_valid || (res_from_sq && res_sq_probed) || (!res_from_sq && res_dc_probed))
    |=> !replay_req);

  // R11
  idle_defaults_chk: assert property (@(posedge clk) disable iff (rst)
    !iss_valid |=> (!ld_valid && sq_en && dc_en));
endmodule

bind ld_gate_pred ld_gate_chk #(.PC_W(PC_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .loop_mode    (loop_mode),
  .cfg_sq_gate  (cfg_sq_gate),
  .cfg_dc_gate  (cfg_dc_gate),
  .iss_valid    (iss_valid),
  .iss_pc       (iss_pc),
  .res_valid    (res_valid),
  .res_pc       (res_pc),
  .res_from_sq  (res_from_sq),
  .res_sq_probed(res_sq_probed),
  .res_dc_probed(res_dc_probed),
  .ld_valid     (ld_valid),
  .sq_en        (sq_en),
  .dc_en        (dc_en),
  .replay_req   (replay_req),
  .replay_sq_en (replay_sq_en)
);

// File: tb/tb_ld_gate_pred.sv
module tb_ld_gate_pred;
  localparam int PERIOD = 10;
  localparam int PC_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic loop_mode = 1'b0, cfg_sq_gate = 1'b0, cfg_dc_gate = 1'b0;
  logic iss_valid = 1'b0, res_valid = 1'b0;
  logic [PC_W-1:0] iss_pc = '0, res_pc = '0;
  logic res_from_sq = 1'b0, res_sq_probed = 1'b1, res_dc_probed = 1'b1;
  logic ld_valid, sq_en, dc_en, replay_req, replay_sq_en;

  int checks = 0;
  int fails = 0;
  bit started = 0;
  string cur_req = "R1";

  // reference model state
  int tbl [64];
  logic e_v, e_sq, e_dc, e_rp, e_rpsq;

  always #(PERIOD/2) clk = ~clk;

  ld_gate_pred dut (
    .clk(clk), .rst(rst), .loop_mode(loop_mode),
    .cfg_sq_gate(cfg_sq_gate), .cfg_dc_gate(cfg_dc_gate),
    .iss_valid(iss_valid), .iss_pc(iss_pc),
    .res_valid(res_valid), .res_pc(res_pc), .res_from_sq(res_from_sq),
    .res_sq_probed(res_sq_probed), .res_dc_probed(res_dc_probed),
    .ld_valid(ld_valid), .sq_en(sq_en), .dc_en(dc_en),
    .replay_req(replay_req), .replay_sq_en(replay_sq_en)
  );

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // behavioural reference, updated at each rising edge
  always @(posedge clk) begin
    int ii, ri;
    bit pred;
    started = 1;
    if (rst) begin
      for (int k = 0; k < 64; k++) tbl[k] = 1;
      e_v <= 0; e_sq <= 1; e_dc <= 1; e_rp <= 0; e_rpsq <= 0;
    end else begin
      ii = int'((iss_pc >> 2) % 64);
      ri = int'((res_pc >> 2) % 64);
      pred = (tbl[ii] >= 2);
      e_v <= iss_valid;
      e_sq <= !(iss_valid && loop_mode && cfg_sq_gate && !pred);
      e_dc <= !(iss_valid && loop_mode && cfg_dc_gate && pred);
      e_rp <= res_valid && ((res_from_sq && !res_sq_probed) || (!res_from_sq && !res_dc_probed));
      e_rpsq <= res_valid && res_from_sq && !res_sq_probed;
      if (res_valid) begin
        if (res_from_sq) tbl[ri] = (tbl[ri] == 3) ? 3 : tbl[ri] + 1;
        else             tbl[ri] = (tbl[ri] == 0) ? 0 : tbl[ri] - 1;
      end
    end
  end

  // model comparison every cycle, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      chk(ld_valid, e_v, cur_req, "model ld_valid");
      chk(sq_en, e_sq, cur_req, "model sq_en");
      chk(dc_en, e_dc, cur_req, "model dc_en");
      chk(replay_req, e_rp, cur_req, "model replay_req");
      chk(replay_sq_en, e_rpsq, cur_req, "model replay_sq_en");
    end
  end

  // drive one cycle of stimulus; returns at the next falling edge with outputs updated
  task automatic step(input logic iv, input logic [PC_W-1:0] ipc,
                      input logic rv, input logic [PC_W-1:0] rpc,
                      input logic fsq, input logic psq, input logic pdc);
    iss_valid = iv; iss_pc = ipc;
    res_valid = rv; res_pc = rpc; res_from_sq = fsq;
    res_sq_probed = psq; res_dc_probed = pdc;
    @(negedge clk);
    iss_valid = 0; res_valid = 0;
  endtask

  task automatic issue(input logic [PC_W-1:0] pc);
    step(1, pc, 0, '0, 0, 1, 1);
  endtask

  task automatic resolve(input logic [PC_W-1:0] pc, input logic fsq, input logic psq, input logic pdc);
    step(0, '0, 1, pc, fsq, psq, pdc);
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    cur_req = "R1";
    chk(sq_en, 1, "R1", "reset sq_en");
    chk(dc_en, 1, "R1", "reset dc_en");
    chk(ld_valid, 0, "R1", "reset ld_valid");
    chk(replay_req, 0, "R1", "reset replay_req");
    rst = 0;
    @(negedge clk);

    // R2 not in loop mode
    cur_req = "R2";
    cfg_sq_gate = 1; cfg_dc_gate = 1; loop_mode = 0;
    issue(32'h100);
    chk(ld_valid, 1, "R2", "ld_valid");
    chk(sq_en, 1, "R2", "sq_en outside loop");
    chk(dc_en, 1, "R2", "dc_en outside loop");

    // R3 fresh counter (R1 init = 1) predicts cache
    cur_req = "R3";
    loop_mode = 1;
    issue(32'h40);
    chk(sq_en, 0, "R3", "sq gated on cache prediction");
    chk(dc_en, 1, "R3", "dc kept");

    // R8 store queue supplied but was off
    cur_req = "R8";
    resolve(32'h40, 1, 0, 1);
    chk(replay_req, 1, "R8", "replay_req");
    chk(replay_sq_en, 1, "R8", "replay_sq_en");

    // R4 counter now 2 -> store-queue prediction
    cur_req = "R4";
    issue(32'h40);
    chk(dc_en, 0, "R4", "dc gated on sq prediction");
    chk(sq_en, 1, "R4", "sq kept");

    // R9 cache supplied but was off
    cur_req = "R9";
    resolve(32'h40, 0, 1, 0);
    chk(replay_req, 1, "R9", "replay_req");
    chk(replay_sq_en, 0, "R9", "replay_sq_en");

    // R7 upper saturation on idx 5
    cur_req = "R7";
    for (int i = 0; i < 5; i++) resolve(32'h14, 1, 1, 1);
    chk(replay_req, 0, "R10", "probed supplier, no replay");
    resolve(32'h14, 0, 1, 1);
    issue(32'h14);
    chk(dc_en, 0, "R7", "saturated high then one step down still sq");
    resolve(32'h14, 0, 1, 1);
    issue(32'h14);
    chk(sq_en, 0, "R7", "counter 1 predicts cache");
    for (int i = 0; i < 3; i++) resolve(32'h14, 0, 1, 1);
    resolve(32'h14, 1, 1, 1);
    issue(32'h14);
    chk(sq_en, 0, "R7", "saturated low then one step up still cache");

    // R11 same-cycle issue and update: issue sees old value (idx16 = 1)
    cur_req = "R11";
    step(1, 32'h40, 1, 32'h40, 1, 1, 1);
    chk(sq_en, 0, "R11", "read before update");
    chk(replay_req, 0, "R10", "no replay when sq probed");
    // R7 aliasing: 0x140 shares idx 16, now 2
    cur_req = "R7";
    issue(32'h140);
    chk(dc_en, 0, "R7", "aliased pc shares counter");
    @(negedge clk);
    chk(ld_valid, 0, "R11", "idle ld_valid");
    chk(sq_en, 1, "R11", "idle sq_en");

    // R5 per-structure configuration
    cur_req = "R5";
    cfg_dc_gate = 0;
    issue(32'h40);
    chk(dc_en, 1, "R5", "dc gating off");
    chk(sq_en, 1, "R5", "sq with sq prediction");
    cfg_dc_gate = 1; cfg_sq_gate = 0;
    issue(32'h14);
    chk(sq_en, 1, "R5", "sq gating off");
    issue(32'h40);
    chk(dc_en, 0, "R5", "dc gating alone active");
    cfg_sq_gate = 1;

    // random traffic checked by the model (R6 and all others)
    cur_req = "R6";
    for (int i = 0; i < 400; i++) begin
      loop_mode = ($urandom_range(0, 3) != 0);
      cfg_sq_gate = ($urandom_range(0, 4) != 0);
      cfg_dc_gate = ($urandom_range(0, 4) != 0);
      step($urandom_range(0, 1), PC_W'($urandom_range(0, 255)) << 2,
           $urandom_range(0, 1), PC_W'($urandom_range(0, 255)) << 2,
           $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
      chk(sq_en | dc_en, 1, "R6", "one probe always on");
    end
    @(negedge clk);
    finish_run();
  end
endmodule